// File: doc/BRIEF.md
# Four-Lane Idle-Column Rate Matcher

This block is an elastic buffer for a four-lane 8b/10b receive path. Decoded columns arrive on a recovered receive clock; each column is one byte plus one control flag per lane. They leave on a local reference clock. The two clocks may differ by up to ±100 PPM, which is 200 PPM in total. The buffer keeps its fill near the middle. It drops idle columns on the write side when the buffer runs full. It repeats idle columns on the read side when the buffer runs empty.

An idle column means that all four lanes carry the idle control code group in the same cycle. A column with the idle code on only some lanes counts as data. Each buffer entry holds a whole column, so lanes can never slip against each other. Rate matching stays off until every lane reports synchronization and the deskew logic reports the lanes aligned. Each inserted or deleted column is reported as a one-cycle pulse on a per-lane flag in the read clock domain.

Both streams are continuous, one column per clock, with no valid/ready handshake. The block cannot apply back-pressure to the incoming stream. Its only ways to absorb rate differences are to drop idle columns and to repeat them.

Top module: `col_rate_match`

## Requirements
- R1: Lane i of a column is `{rx_ctrl[i], rx_data[8i+7:8i]}`, and lane 0 is the least significant byte. A column is idle only when every lane equals control flag 1 with byte 8'h1C. A column with 8'h1C/ctrl 1 on some lanes only passes through as data and is never dropped or repeated.
- R2: Until `lane_locked` is all ones and `lanes_deskewed` is high, no column is stored. During this time the output is the idle column (`col_ctrl` = 4'b1111, every `col_data` byte 8'h1C), and both flag vectors stay zero.
- R3: After enabling, the read side emits idle columns and holds its pointer until its view of the fill reaches MID_MARK (default 16). Only then does it forward stored columns.
- R4: On the write side, an idle column that arrives while the write-side fill is at or above HI_MARK (default 26) is not stored.
- R5: On the read side, when the fill is at or below LO_MARK (default 6) and the head entry is an idle column, the head is output again without being popped. If the buffer is empty, an idle column is output.
- R6: Each dropped column raises all four bits of `col_del` together for exactly one read clock cycle.
- R7: Each repeated column raises all four bits of `col_ins` together for exactly one read clock cycle, in the same cycle as the repeated idle column on the outputs.
- R8: Non-idle columns leave complete, unchanged and in order, with none lost or duplicated. This holds with the read clock equal to, faster than or slower than the write clock.
- R9: No column is written into a full buffer, and no entry is popped from an empty one.
- R10: While either reset is asserted, and directly after reset, the outputs show the idle column and both flag vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock (write side) |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| rx_data | input | 32 | Incoming column bytes, lane i in bits 8i+7:8i |
| rx_ctrl | input | 4 | Incoming control flags, one per lane |
| lane_locked | input | 4 | Per-lane synchronization status |
| lanes_deskewed | input | 1 | Lane alignment status |
| rclk | input | 1 | Local reference clock (read side) |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| col_data | output | 32 | Outgoing column bytes |
| col_ctrl | output | 4 | Outgoing control flags |
| col_ins | output | 4 | Per-lane pulse for each repeated idle column |
| col_del | output | 4 | Per-lane pulse for each dropped idle column |

## Verification
The bench uses the default parameters: 32 entries, a priming mark of 16, a drop mark of 26 and a repeat mark of 6. With these marks, the synchronizer lag of two to three cycles in each direction never pushes either side's view of the fill across a threshold when both clocks run at the same rate. The rate scenarios run the read clock 2.5 % faster or slower than the write clock. This exaggerates the drift so that thresholds are crossed within a few hundred cycles, and it triggers runs of back-to-back drops and repeats inside idle gaps of three to six columns.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int LANE_W = 9;
  localparam logic [7:0] IDLE_BYTE = 8'h1C;

  typedef enum logic {
    RD_PRIME = 1'b0,
    RD_RUN   = 1'b1
  } rd_state_e;

  function automatic logic lane_idle(input logic [LANE_W-1:0] ln);
    return ln == {1'b1, IDLE_BYTE};
  endfunction
endpackage

// File: rtl/rm_idle_det.sv
module rm_idle_det #(
  parameter int LANES = 4
) (
  input  logic [LANES*rm_pkg::LANE_W-1:0] col,
  output logic                            is_idle
);
  logic [LANES-1:0] hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = rm_pkg::lane_idle(col[i*rm_pkg::LANE_W +: rm_pkg::LANE_W]);
  end

  assign is_idle = &hit;
endmodule

// File: rtl/rm_gray_xfer.sv
module rm_gray_xfer #(
  parameter int W = 6
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] g_src, g_meta, g_dst;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) g_src <= '0;
    else            g_src <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      g_meta <= '0;
      g_dst  <= '0;
    end else begin
      g_meta <= g_src;
      g_dst  <= g_meta;
    end
  end

  always_comb begin
    logic [W-1:0] acc;
    acc[W-1] = g_dst[W-1];
    for (int i = W - 2; i >= 0; i--) acc[i] = acc[i+1] ^ g_dst[i];
    dst_bin = acc;
  end
endmodule

// File: rtl/rm_col_ram.sv
module rm_col_ram #(
  parameter int AW = 5,
  parameter int CW = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rm_wr_ctrl.sv
module rm_wr_ctrl #(
  parameter int LANES   = 4,
  parameter int AW      = 5,
  parameter int HI_MARK = 26,
  localparam int CW     = LANES * rm_pkg::LANE_W,
  localparam int PW     = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    col_in,
  input  logic [LANES-1:0] lane_ok,
  input  logic             aligned,
  input  logic [PW-1:0]    rd_ptr_s,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [CW-1:0]    wdata,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    del_cnt,
  output logic             run_w,
  output logic [PW-1:0]    fill
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] col_q;
  logic          idle_q, drop, full;

  rm_idle_det #(.LANES(LANES)) u_det (.col(col_q), .is_idle(idle_q));

  assign fill  = wr_ptr - rd_ptr_s;
  assign full  = (fill == PW'(DEPTH));
  assign drop  = run_w && idle_q && (fill >= PW'(HI_MARK));
  assign we    = run_w && !drop && !full;
  assign waddr = wr_ptr[AW-1:0];
  assign wdata = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      run_w   <= 1'b0;
      wr_ptr  <= '0;
      del_cnt <= '0;
    end else begin
      col_q <= col_in;
      run_w <= (&lane_ok) && aligned;
      if (we)   wr_ptr  <= wr_ptr + 1'b1;
      if (drop) del_cnt <= del_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rm_rd_ctrl.sv
module rm_rd_ctrl #(
  parameter int LANES    = 4,
  parameter int AW       = 5,
  parameter int LO_MARK  = 6,
  parameter int MID_MARK = 16,
  localparam int CW      = LANES * rm_pkg::LANE_W,
  localparam int PW      = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_req,
  input  logic [PW-1:0]       wr_ptr_s,
  input  logic [PW-1:0]       del_cnt_s,
  input  logic [CW-1:0]       head,
  output logic [PW-1:0]       rd_ptr,
  output logic [CW-1:0]       col_out,
  output logic [LANES-1:0]    ins_evt,
  output logic [LANES-1:0]    del_evt,
  output logic [PW-1:0]       fill,
  output logic                pop,
  output rm_pkg::rd_state_e   state
);
  localparam logic [CW-1:0] IDLE_COL = {LANES{{1'b1, rm_pkg::IDLE_BYTE}}};

  logic              run_m, run_s, head_idle, ins, del_pend;
  logic [CW-1:0]     nxt_col;
  logic [PW-1:0]     del_seen;
  rm_pkg::rd_state_e nxt_state;

  rm_idle_det #(.LANES(LANES)) u_det (.col(head), .is_idle(head_idle));

  assign fill     = wr_ptr_s - rd_ptr;
  assign del_pend = (del_seen != del_cnt_s);

  always_comb begin
    nxt_state = state;
    nxt_col   = IDLE_COL;
    pop       = 1'b0;
    ins       = 1'b0;
    case (state)
      rm_pkg::RD_PRIME: begin
        if (!run_s)                         pop = (fill != '0);
        else if (fill >= PW'(MID_MARK))     nxt_state = rm_pkg::RD_RUN;
      end
      rm_pkg::RD_RUN: begin
        if (!run_s) begin
          nxt_state = rm_pkg::RD_PRIME;
        end else if (fill == '0) begin
          ins = 1'b1;
        end else if ((fill <= PW'(LO_MARK)) && head_idle) begin
          ins     = 1'b1;
          nxt_col = head;
        end else begin
          pop     = 1'b1;
          nxt_col = head;
        end
      end
      default: nxt_state = rm_pkg::RD_PRIME;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_m    <= 1'b0;
      run_s    <= 1'b0;
      state    <= rm_pkg::RD_PRIME;
      rd_ptr   <= '0;
      col_out  <= IDLE_COL;
      ins_evt  <= '0;
      del_evt  <= '0;
      del_seen <= '0;
    end else begin
      run_m   <= run_req;
      run_s   <= run_m;
      state   <= nxt_state;
      col_out <= nxt_col;
      ins_evt <= {LANES{ins}};
      del_evt <= {LANES{del_pend}};
      if (pop)      rd_ptr   <= rd_ptr + 1'b1;
      if (del_pend) del_seen <= del_seen + 1'b1;
    end
  end
endmodule

// File: rtl/col_rate_match.sv
module col_rate_match #(
  parameter int LANES    = 4,
  parameter int AW       = 5,
  parameter int HI_MARK  = 26,
  parameter int LO_MARK  = 6,
  parameter int MID_MARK = 16
) (
  input  logic               wclk,
  input  logic               wrst_n,
  input  logic [LANES*8-1:0] rx_data,
  input  logic [LANES-1:0]   rx_ctrl,
  input  logic [LANES-1:0]   lane_locked,
  input  logic               lanes_deskewed,
  input  logic               rclk,
  input  logic               rrst_n,
  output logic [LANES*8-1:0] col_data,
  output logic [LANES-1:0]   col_ctrl,
  output logic [LANES-1:0]   col_ins,
  output logic [LANES-1:0]   col_del
);
  localparam int LW = rm_pkg::LANE_W;
  localparam int CW = LANES * LW;
  localparam int PW = AW + 1;

  logic [CW-1:0]     col_in, col_out, wdata, head;
  logic [PW-1:0]     wr_ptr, rd_ptr, wr_ptr_s, rd_ptr_s, del_cnt, del_cnt_s;
  logic [PW-1:0]     wr_fill, rd_fill;
  logic [AW-1:0]     waddr;
  logic              we, run_w, pop;
  rm_pkg::rd_state_e rd_state;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign col_in[i*LW +: LW] = {rx_ctrl[i], rx_data[i*8 +: 8]};
    assign col_ctrl[i]        = col_out[i*LW + 8];
    assign col_data[i*8 +: 8] = col_out[i*LW +: 8];
  end

  rm_wr_ctrl #(.LANES(LANES), .AW(AW), .HI_MARK(HI_MARK)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .col_in(col_in), .lane_ok(lane_locked),
    .aligned(lanes_deskewed), .rd_ptr_s(rd_ptr_s), .we(we), .waddr(waddr),
    .wdata(wdata), .wr_ptr(wr_ptr), .del_cnt(del_cnt), .run_w(run_w),
    .fill(wr_fill)
  );

  rm_col_ram #(.AW(AW), .CW(CW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_ptr[AW-1:0]), .rdata(head)
  );

  rm_gray_xfer #(.W(PW)) u_wp_x (
    .src_clk(wclk), .src_rst_n(wrst_n), .src_bin(wr_ptr),
    .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(wr_ptr_s)
  );

  rm_gray_xfer #(.W(PW)) u_rp_x (
    .src_clk(rclk), .src_rst_n(rrst_n), .src_bin(rd_ptr),
    .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(rd_ptr_s)
  );

  rm_gray_xfer #(.W(PW)) u_dc_x (
    .src_clk(wclk), .src_rst_n(wrst_n), .src_bin(del_cnt),
    .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(del_cnt_s)
  );

  rm_rd_ctrl #(.LANES(LANES), .AW(AW), .LO_MARK(LO_MARK), .MID_MARK(MID_MARK)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .run_req(run_w), .wr_ptr_s(wr_ptr_s),
    .del_cnt_s(del_cnt_s), .head(head), .rd_ptr(rd_ptr), .col_out(col_out),
    .ins_evt(col_ins), .del_evt(col_del), .fill(rd_fill), .pop(pop),
    .state(rd_state)
  );
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
  parameter int LANES = 4,
  parameter int AW    = 5,
  localparam int PW   = AW + 1
) (
  input logic               wclk,
  input logic               wrst_n,
  input logic               rclk,
  input logic               rrst_n,
  input logic               we,
  input logic               run_w,
  input logic [PW-1:0]      wr_fill,
  input logic               pop,
  input logic [PW-1:0]      rd_fill,
  input logic               rd_run,
  input logic [LANES*8-1:0] col_data,
  input logic [LANES-1:0]   col_ctrl,
  input logic [LANES-1:0]   col_ins,
  input logic [LANES-1:0]   col_del
);
  localparam int DEPTH = 1 << AW;
  logic out_idle;
  assign out_idle = (col_ctrl == '1) && (col_data == {LANES{8'h1C}});

  p_no_overflow_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
    we |-> (wr_fill < PW'(DEPTH)));

  p_no_underrun_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |-> (rd_fill != '0));

  p_write_gated_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    !run_w |-> !we);

  p_idle_while_stopped_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_run |=> (out_idle && (col_ins == '0)));

  p_ins_on_idle_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (col_ins != '0) |-> out_idle);

  p_ins_all_lanes_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (col_ins == '0) || (col_ins == '1));

  p_del_all_lanes_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (col_del == '0) || (col_del == '1));
endmodule

bind col_rate_match rm_checker #(.LANES(LANES), .AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .we(we), .run_w(run_w), .wr_fill(wr_fill), .pop(pop), .rd_fill(rd_fill),
  .rd_run(rd_state == rm_pkg::RD_RUN), .col_data(col_data),
  .col_ctrl(col_ctrl), .col_ins(col_ins), .col_del(col_del)
);

// File: tb/tb_col_rate_match.sv
`timescale 1ps/1ps
module tb_col_rate_match;
  localparam int LANES  = 4;
  localparam int MID    = 16;
  localparam int DLEN   = 12;
  localparam int N_COLS = 1500;
  // read period (ps), idle run length, expect repeats, expect drops
  localparam int VEC [3][4] = '{'{4000, 4, 0, 0}, '{3900, 3, 1, 0}, '{4100, 6, 0, 1}};

  logic               wclk, rclk, wrst_n, rrst_n, lanes_deskewed;
  logic [LANES*8-1:0] rx_data, col_data;
  logic [LANES-1:0]   rx_ctrl, lane_locked, col_ctrl, col_ins, col_del;
  int rper = 4000;
  int checks = 0, fails = 0;

  col_rate_match dut (
    .wclk(wclk), .wrst_n(wrst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .lane_locked(lane_locked), .lanes_deskewed(lanes_deskewed),
    .rclk(rclk), .rrst_n(rrst_n), .col_data(col_data), .col_ctrl(col_ctrl),
    .col_ins(col_ins), .col_del(col_del)
  );

  initial begin wclk = 0; forever #2000 wclk = ~wclk; end
  initial begin rclk = 0; forever #(rper / 2) rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- generator (write domain) ----------------
  int gen_mode = 0, gen_seq = 0, gen_sent = 0, gen_target = 0, gen_ilen = 4, gen_pos = 0;
  initial begin
    rx_data = {LANES{8'h1C}};
    rx_ctrl = '1;
    forever begin
      @(negedge wclk);
      if (gen_mode != 0 && gen_sent < gen_target && gen_pos < DLEN) begin
        rx_data = {(gen_seq[0] ? 8'h1C : 8'h3C), 8'hA5, gen_seq[15:8], gen_seq[7:0]};
        rx_ctrl = {gen_seq[0], 3'b000};
        gen_seq++;
        gen_sent++;
      end else begin
        rx_data = {LANES{8'h1C}};
        rx_ctrl = '1;
      end
      if (gen_mode != 0) gen_pos = (gen_pos + 1) % (DLEN + gen_ilen);
    end
  end

  // ---------------- monitor (read domain) ----------------
  bit mon_on = 0, first_seen = 0;
  int exp_seq = 0, nonidle = 0, ins_n = 0, del_n = 0, mixed = 0, part_n = 0;
  int mon_cyc = 0, first_cyc = 0;

  task automatic mon_clear();
    exp_seq = 0; nonidle = 0; ins_n = 0; del_n = 0; mixed = 0; part_n = 0;
    mon_cyc = 0; first_cyc = 0; first_seen = 0;
  endtask

  initial forever begin
    @(negedge rclk);
    if (mon_on) begin
      logic idle;
      logic [15:0] got;
      logic [8:0] l3;
      mon_cyc++;
      idle = (col_ctrl == '1) && (col_data == {LANES{8'h1C}});
      if (col_ins == '1) ins_n++;
      if (col_del == '1) del_n++;
      if ((col_ins != '0 && col_ins != '1) || (col_del != '0 && col_del != '1)) mixed++;
      if (col_ins != '0) chk(idle, "R7", "repeat flag with non-idle column", 0, 1);
      if (!idle) begin
        nonidle++;
        got = {col_data[15:8], col_data[7:0]};
        l3  = {col_ctrl[3], col_data[31:24]};
        if (!first_seen) begin first_seen = 1; first_cyc = mon_cyc; end
        if (l3 == 9'h11C) part_n++;
        chk(got == exp_seq[15:0] && col_data[23:16] == 8'hA5 && col_ctrl[2:0] == 3'b000 &&
            l3 == (got[0] ? 9'h11C : 9'h03C), "R8", "data column order/content", int'(got), exp_seq);
        exp_seq = int'(got) + 1;
      end
    end
  end

  task automatic do_reset(input int rp);
    mon_on = 0;
    gen_mode = 0; gen_sent = 0; gen_seq = 0; gen_pos = 0; gen_target = 0;
    @(negedge wclk);
    rper = rp;
    wrst_n = 0; rrst_n = 0; lane_locked = '0; lanes_deskewed = 0;
    repeat (6) @(negedge wclk);
    chk(col_ctrl == '1 && col_data == {LANES{8'h1C}} && col_ins == '0 && col_del == '0,
        "R10", "outputs during reset", int'(col_ctrl), 15);
    wrst_n = 1; rrst_n = 1;
    @(negedge rclk);
    chk(col_ctrl == '1 && col_data == {LANES{8'h1C}} && col_ins == '0 && col_del == '0,
        "R10", "outputs after reset", int'(col_ins | col_del), 0);
  endtask

  task automatic run_vec(input int rp, input int ilen, input int ei, input int ed);
    do_reset(rp);
    @(negedge wclk);
    lane_locked = '1; lanes_deskewed = 1;
    repeat (60) @(negedge wclk);
    mon_clear();
    mon_on = 1;
    gen_seq = 0; gen_sent = 0; gen_pos = 0; gen_ilen = ilen; gen_target = N_COLS; gen_mode = 1;
    wait (gen_sent == N_COLS);
    repeat (200) @(negedge wclk);
    mon_on = 0;
    chk(exp_seq == N_COLS, "R8", "data columns delivered", exp_seq, N_COLS);
    chk(part_n == N_COLS / 2, "R1", "partial-idle columns delivered", part_n, N_COLS / 2);
    chk(mixed == 0, "R6", "flag lanes disagree", mixed, 0);
    chk((ins_n > 0) == (ei != 0), "R5", "repeats present", ins_n, ei);
    chk((del_n > 0) == (ed != 0), "R4", "drops present", del_n, ed);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(64'd400_000_000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    wrst_n = 0; rrst_n = 0; lane_locked = '0; lanes_deskewed = 0;

    // R2: one lane not synchronized
    do_reset(4000);
    @(negedge wclk);
    lane_locked = 4'b1101; lanes_deskewed = 1;
    mon_clear(); mon_on = 1;
    gen_target = 100; gen_ilen = 4; gen_mode = 1;
    repeat (150) @(negedge wclk);
    mon_on = 0;
    chk(nonidle == 0 && ins_n == 0 && del_n == 0, "R2", "output with one lane unlocked", nonidle + ins_n + del_n, 0);

    // R2: all synchronized, lanes not aligned
    do_reset(4000);
    @(negedge wclk);
    lane_locked = '1; lanes_deskewed = 0;
    mon_clear(); mon_on = 1;
    gen_target = 100; gen_ilen = 4; gen_mode = 1;
    repeat (150) @(negedge wclk);
    mon_on = 0;
    chk(nonidle == 0 && ins_n == 0 && del_n == 0, "R2", "output with lanes unaligned", nonidle + ins_n + del_n, 0);

    // R3: priming delay before the first stored column leaves
    do_reset(4000);
    @(negedge wclk);
    mon_clear(); mon_on = 1;
    gen_target = 200; gen_ilen = 4; gen_mode = 1;
    lane_locked = '1; lanes_deskewed = 1;
    repeat (300) @(negedge wclk);
    mon_on = 0;
    chk(first_seen && first_cyc >= MID && first_cyc <= MID + 12, "R3", "cycles to first data", first_cyc, MID);
    chk(exp_seq == 200, "R8", "data after priming", exp_seq, 200);

    // R4 R5 R6 R7 R8 across rates
    for (int v = 0; v < 3; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    report();
    $finish;
  end
endmodule